// File: doc/BRIEF.md
# Bundle Slot Single-Step Sequencer

This block keeps the resume position of a processor that fetches instructions in three-slot bundles. The position is a bundle address plus a slot index. A return-from-interruption operation loads the position and the single-step enable from a saved status copy. Each accepted retire pulse then moves the position to the instruction that follows. A long-immediate template fills slots 1 and 2 with one instruction, so stepping slot 1 of that template moves the position on to the next bundle.

When single-step mode is on, one retired instruction raises a one-cycle step trap request. That instruction may be native or legacy-ISA. After the trap, further retire pulses are ignored until the trap is acknowledged. A legacy-ISA retire counts as one instruction for stepping but leaves the native bundle position alone.

Top module: `step_seq_top`

## Requirements
- R1: After reset, the bundle pointer is 0, the slot index is 0, the step trap is low and single-step mode is off.
- R2: A return-from-interruption load sets the bundle pointer to the saved pointer with its low 4 bits cleared, the slot index to the saved slot (the reserved value 3 loads as 0) and the step enable to the saved bit. It clears any pending trap and takes priority over a retire in the same cycle.
- R3: An accepted native retire at slot 0, or at slot 1 with a template that is not long-immediate, increments the slot index and leaves the pointer unchanged.
- R4: An accepted native retire at slot 2 adds 16 to the bundle pointer and sets the slot index to 0.
- R5: With template code 4 or 5 (long-immediate), a native retire at slot 1 adds 16 to the pointer and sets the slot index to 0. A native retire at slot 0 with the same template goes to slot 1.
- R6: With single-step on, an accepted retire drives the step trap high for exactly the one cycle after the retire edge.
- R7: With single-step off, a retire raises no trap, and the position still advances.
- R8: After a step trap, retire pulses leave the position unchanged and raise no trap until the trap acknowledge input is seen. After that, retires are accepted again.
- R9: A retire with the legacy-ISA flag set leaves the pointer and slot unchanged and raises the trap when single-step is on.
- R10: The bundle pointer wraps modulo 2^ADDR_W when it advances past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rfi_load_i | input | 1 | Return-from-interruption load strobe |
| rfi_ss_i | input | 1 | Saved single-step enable |
| rfi_ptr_i | input | ADDR_W | Saved bundle pointer |
| rfi_slot_i | input | 2 | Saved slot index |
| retire_i | input | 1 | One-cycle instruction retire pulse |
| tmpl_i | input | TMPL_W | Template code of the bundle being retired |
| legacy_i | input | 1 | Retired instruction belongs to the legacy ISA |
| trap_ack_i | input | 1 | Acknowledge of the pending step trap |
| next_ptr_o | output | ADDR_W | Bundle pointer of the resume position |
| next_slot_o | output | 2 | Slot index of the resume position |
| step_trap_o | output | 1 | Single-step trap request pulse |

## Verification
The assertions run on every cycle. They cover the one-cycle trap pulse, pointer alignment, the reserved slot value never showing, the frozen position while a trap is pending, the slot-2 and slot-0 transitions, and the result of a load. Only the bench scenarios show the template-dependent wrap over all template codes, legacy retires, wrap at the top of the address space, and a load beating a retire in the same cycle. The bench sweeps every slot, template code, ISA flag and step setting and compares each result with values it computes itself.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
   typedef logic [1:0] slot_t;

   localparam slot_t SLOT_FIRST = 2'd0;
   localparam slot_t SLOT_MID   = 2'd1;
   localparam slot_t SLOT_LAST  = 2'd2;

   // the reserved index 3 maps back to the first slot
   function automatic slot_t legal_slot(input slot_t s);
      return (s == 2'd3) ? SLOT_FIRST : s;
   endfunction
endpackage

// File: rtl/step_slot_calc.sv
module step_slot_calc
   import step_seq_pkg::*;
#(
   parameter int unsigned ADDR_W       = 64,
   parameter int unsigned TMPL_W       = 5,
   parameter int unsigned BUNDLE_BYTES = 16,
   parameter int unsigned LONG_CODE_A  = 4,
   parameter int unsigned LONG_CODE_B  = 5,
   parameter bit          LONG_EN      = 1'b1
) (
   input  logic [ADDR_W-1:0] cur_ptr_i,
   input  slot_t             cur_slot_i,
   input  logic [TMPL_W-1:0] tmpl_i,
   output logic [ADDR_W-1:0] nxt_ptr_o,
   output slot_t             nxt_slot_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BUNDLE_BYTES);
   localparam logic [TMPL_W-1:0] CODE_A = TMPL_W'(LONG_CODE_A);
   localparam logic [TMPL_W-1:0] CODE_B = TMPL_W'(LONG_CODE_B);

   logic is_long;
   logic leave_bundle;

   generate
      if (LONG_EN) begin : g_long
         assign is_long = (tmpl_i == CODE_A) || (tmpl_i == CODE_B);
      end else begin : g_nolong
         assign is_long = 1'b0;
      end
   endgenerate

   always_comb begin
      leave_bundle = (cur_slot_i == SLOT_LAST) ||
                     (is_long && (cur_slot_i == SLOT_MID));
      if (leave_bundle) begin
         nxt_ptr_o  = cur_ptr_i + STEP;
         nxt_slot_o = SLOT_FIRST;
      end else begin
         nxt_ptr_o  = cur_ptr_i;
         nxt_slot_o = legal_slot(cur_slot_i + 2'd1);
      end
   end
endmodule

// File: rtl/step_pos_reg.sv
module step_pos_reg
   import step_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned ALIGN_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_ptr_i,
   input  slot_t             load_slot_i,
   input  logic              adv_i,
   input  logic [ADDR_W-1:0] adv_ptr_i,
   input  slot_t             adv_slot_i,
   output logic [ADDR_W-1:0] ptr_o,
   output slot_t             slot_o
);
   localparam logic [ADDR_W-1:0] MASK =
      {{(ADDR_W-ALIGN_LSB){1'b1}}, {ALIGN_LSB{1'b0}}};

   logic [ADDR_W-1:0] ptr_q;
   slot_t             slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         slot_q <= SLOT_FIRST;
      end else if (load_i) begin
         ptr_q  <= load_ptr_i & MASK;
         slot_q <= legal_slot(load_slot_i);
      end else if (adv_i) begin
         ptr_q  <= adv_ptr_i;
         slot_q <= adv_slot_i;
      end
   end

   assign ptr_o  = ptr_q;
   assign slot_o = slot_q;
endmodule

// File: rtl/step_trap_ctl.sv
module step_trap_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic rfi_load_i,
   input  logic rfi_ss_i,
   input  logic retire_i,
   input  logic ack_i,
   output logic accept_o,
   output logic trap_o,
   output logic pend_o,
   output logic ss_o
);
   logic ss_q;
   logic pend_q;
   logic trap_q;
   logic accept;

   assign accept = retire_i && !pend_q && !rfi_load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_q   <= 1'b0;
         pend_q <= 1'b0;
         trap_q <= 1'b0;
      end else begin
         trap_q <= accept && ss_q;
         if (rfi_load_i) begin
            ss_q   <= rfi_ss_i;
            pend_q <= 1'b0;
         end else if (pend_q && ack_i) begin
            pend_q <= 1'b0;
         end else if (accept && ss_q) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign accept_o = accept;
   assign trap_o   = trap_q;
   assign pend_o   = pend_q;
   assign ss_o     = ss_q;
endmodule

// File: rtl/step_seq_top.sv
module step_seq_top
   import step_seq_pkg::*;
#(
   parameter int unsigned ADDR_W       = 64,
   parameter int unsigned TMPL_W       = 5,
   parameter int unsigned BUNDLE_BYTES = 16,
   parameter int unsigned LONG_CODE_A  = 4,
   parameter int unsigned LONG_CODE_B  = 5,
   parameter bit          LONG_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rfi_load_i,
   input  logic              rfi_ss_i,
   input  logic [ADDR_W-1:0] rfi_ptr_i,
   input  logic [1:0]        rfi_slot_i,
   input  logic              retire_i,
   input  logic [TMPL_W-1:0] tmpl_i,
   input  logic              legacy_i,
   input  logic              trap_ack_i,
   output logic [ADDR_W-1:0] next_ptr_o,
   output logic [1:0]        next_slot_o,
   output logic              step_trap_o
);
   localparam int unsigned ALIGN_LSB = $clog2(BUNDLE_BYTES);

   generate
      if ((1 << ALIGN_LSB) != BUNDLE_BYTES) begin : g_bad_bundle
         $error("BUNDLE_BYTES must be a power of two");
      end
      if (ADDR_W <= ALIGN_LSB) begin : g_bad_addr
         $error("ADDR_W must exceed the bundle alignment bits");
      end
      if (LONG_CODE_A >= (1 << TMPL_W) || LONG_CODE_B >= (1 << TMPL_W)) begin : g_bad_code
         $error("long template codes must fit in TMPL_W");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr_q;
   slot_t             slot_q;
   logic [ADDR_W-1:0] adv_ptr;
   slot_t             adv_slot;
   logic              accept;
   logic              pend_q;
   logic              ss_q;
   logic              trap_q;
   logic              native_adv;

   step_trap_ctl u_trap (
      .clk        (clk),
      .rst_n      (rst_n),
      .rfi_load_i (rfi_load_i),
      .rfi_ss_i   (rfi_ss_i),
      .retire_i   (retire_i),
      .ack_i      (trap_ack_i),
      .accept_o   (accept),
      .trap_o     (trap_q),
      .pend_o     (pend_q),
      .ss_o       (ss_q)
   );

   step_slot_calc #(
      .ADDR_W       (ADDR_W),
      .TMPL_W       (TMPL_W),
      .BUNDLE_BYTES (BUNDLE_BYTES),
      .LONG_CODE_A  (LONG_CODE_A),
      .LONG_CODE_B  (LONG_CODE_B),
      .LONG_EN      (LONG_EN)
   ) u_calc (
      .cur_ptr_i  (ptr_q),
      .cur_slot_i (slot_q),
      .tmpl_i     (tmpl_i),
      .nxt_ptr_o  (adv_ptr),
      .nxt_slot_o (adv_slot)
   );

   assign native_adv = accept && !legacy_i;

   step_pos_reg #(
      .ADDR_W    (ADDR_W),
      .ALIGN_LSB (ALIGN_LSB)
   ) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (rfi_load_i),
      .load_ptr_i  (rfi_ptr_i),
      .load_slot_i (rfi_slot_i),
      .adv_i       (native_adv),
      .adv_ptr_i   (adv_ptr),
      .adv_slot_i  (adv_slot),
      .ptr_o       (ptr_q),
      .slot_o      (slot_q)
   );

   assign next_ptr_o  = ptr_q;
   assign next_slot_o = slot_q;
   assign step_trap_o = trap_q;
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk #(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned ALIGN_LSB = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rfi_load_i,
   input logic [ADDR_W-1:0] rfi_ptr_i,
   input logic              retire_i,
   input logic              legacy_i,
   input logic              pend,
   input logic              ss,
   input logic [ADDR_W-1:0] next_ptr_o,
   input logic [1:0]        next_slot_o,
   input logic              step_trap_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_LSB;

   logic go;
   assign go = retire_i && !pend && !rfi_load_i && !legacy_i;

   AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      step_trap_o |=> !step_trap_o); // R6
   AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      next_ptr_o[ALIGN_LSB-1:0] == '0); // R2
   AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      next_slot_o != 2'd3); // R2
   AST_SLOT2_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (go && next_slot_o == 2'd2) |=>
      (next_slot_o == 2'd0 && next_ptr_o == $past(next_ptr_o) + STEP)); // R4
   AST_SLOT0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (go && next_slot_o == 2'd0) |=>
      (next_slot_o == 2'd1 && $stable(next_ptr_o))); // R3
   AST_PEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !rfi_load_i) |=>
      ($stable(next_ptr_o) && $stable(next_slot_o) && !step_trap_o)); // R8
   AST_TRAP_NEEDS_SS: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && !ss) |=> !step_trap_o); // R7
   AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      rfi_load_i |=> next_ptr_o[ADDR_W-1:ALIGN_LSB] ==
                     $past(rfi_ptr_i[ADDR_W-1:ALIGN_LSB])); // R2
endmodule

bind step_seq_top step_seq_chk #(
   .ADDR_W    (ADDR_W),
   .ALIGN_LSB (ALIGN_LSB)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rfi_load_i  (rfi_load_i),
   .rfi_ptr_i   (rfi_ptr_i),
   .retire_i    (retire_i),
   .legacy_i    (legacy_i),
   .pend        (pend_q),
   .ss          (ss_q),
   .next_ptr_o  (next_ptr_o),
   .next_slot_o (next_slot_o),
   .step_trap_o (step_trap_o)
);

// File: tb/step_seq_top_tb.sv
module step_seq_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int TW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rfi_load_i = 1'b0;
   logic          rfi_ss_i = 1'b0;
   logic [AW-1:0] rfi_ptr_i = '0;
   logic [1:0]    rfi_slot_i = '0;
   logic          retire_i = 1'b0;
   logic [TW-1:0] tmpl_i = '0;
   logic          legacy_i = 1'b0;
   logic          trap_ack_i = 1'b0;
   logic [AW-1:0] next_ptr_o;
   logic [1:0]    next_slot_o;
   logic          step_trap_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   step_seq_top #(.ADDR_W(AW), .TMPL_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rfi_load_i(rfi_load_i), .rfi_ss_i(rfi_ss_i),
      .rfi_ptr_i(rfi_ptr_i), .rfi_slot_i(rfi_slot_i), .retire_i(retire_i),
      .tmpl_i(tmpl_i), .legacy_i(legacy_i), .trap_ack_i(trap_ack_i),
      .next_ptr_o(next_ptr_o), .next_slot_o(next_slot_o), .step_trap_o(step_trap_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_load(input logic [AW-1:0] p, input logic [1:0] s, input logic ss);
      @(negedge clk);
      rfi_load_i = 1'b1; rfi_ptr_i = p; rfi_slot_i = s; rfi_ss_i = ss;
      tick();
      @(negedge clk);
      rfi_load_i = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk);
      trap_ack_i = 1'b1;
      tick();
      @(negedge clk);
      trap_ack_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] base, eptr;
      logic [1:0]    eslot;
      bit            wrapb;
      string         rq;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(next_ptr_o == 0, "R1 ptr", next_ptr_o, 0);
      chk(next_slot_o == 0, "R1 slot", next_slot_o, 0);
      chk(step_trap_o == 0, "R1 trap", step_trap_o, 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 step mode off: a retire raises no trap
      @(negedge clk); retire_i = 1'b1; tick();
      chk(step_trap_o == 0, "R1 ss off", step_trap_o, 0);
      @(negedge clk); retire_i = 1'b0;

      for (int s = 0; s < 3; s++)
         for (int t = 0; t < 32; t++)
            for (int lg = 0; lg < 2; lg++)
               for (int ss = 0; ss < 2; ss++) begin
                  base = AW'((((s * 32 + t) * 4 + lg * 2 + ss) * 16 + 256));
                  do_load(base | AW'(7), 2'(s), 1'(ss));
                  chk(next_ptr_o == base, "R2 load ptr", next_ptr_o, base);
                  chk(next_slot_o == 2'(s), "R2 load slot", next_slot_o, s);
                  wrapb = (s == 2) || (s == 1 && (t == 4 || t == 5));
                  if (lg == 1) begin
                     eptr = base; eslot = 2'(s); rq = "R9";
                  end else if (wrapb) begin
                     eptr = base + 16; eslot = 0;
                     rq = (s == 2) ? "R4" : "R5";
                  end else begin
                     eptr = base; eslot = 2'(s + 1);
                     rq = (t == 4 || t == 5) ? "R5" : "R3";
                  end
                  @(negedge clk);
                  retire_i = 1'b1; tmpl_i = TW'(t); legacy_i = 1'(lg);
                  tick();
                  chk(next_ptr_o == eptr, {rq, " ptr"}, next_ptr_o, eptr);
                  chk(next_slot_o == eslot, {rq, " slot"}, next_slot_o, eslot);
                  chk(step_trap_o == 1'(ss), ss ? "R6 trap" : "R7 no trap", step_trap_o, ss);
                  @(negedge clk);
                  retire_i = 1'b0;
                  tick();
                  chk(step_trap_o == 0, "R6 pulse width", step_trap_o, 0);
                  if (ss == 1) begin
                     @(negedge clk); retire_i = 1'b1; legacy_i = 1'b0;
                     tick();
                     chk(next_ptr_o == eptr && next_slot_o == eslot, "R8 hold",
                         {next_ptr_o, 6'b0, next_slot_o}, {eptr, 6'b0, eslot});
                     @(negedge clk); retire_i = 1'b0;
                     tick();
                     chk(step_trap_o == 0, "R8 no trap", step_trap_o, 0);
                     do_ack();
                  end
               end

      // R8 retire accepted again after ack
      do_load(16'h0040, 2'd0, 1'b1);
      @(negedge clk); retire_i = 1'b1; tmpl_i = 0; legacy_i = 0; tick();
      @(negedge clk); retire_i = 1'b0;
      do_ack();
      @(negedge clk); retire_i = 1'b1; tick();
      chk(next_slot_o == 2 && step_trap_o == 1, "R8 after ack",
          {next_slot_o, step_trap_o}, {2'd2, 1'b1});
      @(negedge clk); retire_i = 1'b0;
      do_ack();

      // R10 wrap at top of address space
      do_load(16'hFFF0, 2'd2, 1'b0);
      @(negedge clk); retire_i = 1'b1; tmpl_i = 0; tick();
      chk(next_ptr_o == 0 && next_slot_o == 0, "R10 wrap",
          {next_ptr_o, next_slot_o}, 18'h0);
      @(negedge clk); retire_i = 1'b0;

      // R2 reserved slot 3 loads as 0
      do_load(16'h1230, 2'd3, 1'b0);
      chk(next_slot_o == 0, "R2 slot3", next_slot_o, 0);

      // R2 load has priority over a same-cycle retire
      @(negedge clk);
      rfi_load_i = 1'b1; rfi_ptr_i = 16'h5550; rfi_slot_i = 2'd1; rfi_ss_i = 1'b1;
      retire_i = 1'b1; tmpl_i = 0;
      tick();
      chk(next_ptr_o == 16'h5550 && next_slot_o == 1, "R2 priority",
          {next_ptr_o, next_slot_o}, {16'h5550, 2'd1});
      chk(step_trap_o == 0, "R2 priority trap", step_trap_o, 0);
      @(negedge clk); rfi_load_i = 1'b0; retire_i = 1'b0;

      // R2 load clears a pending trap
      @(negedge clk); retire_i = 1'b1; tick();
      @(negedge clk); retire_i = 1'b0;
      do_load(16'h7770, 2'd0, 1'b1);
      @(negedge clk); retire_i = 1'b1; tick();
      chk(next_slot_o == 1 && step_trap_o == 1, "R2 pend clear",
          {next_slot_o, step_trap_o}, {2'd1, 1'b1});
      @(negedge clk); retire_i = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule